// File: doc/BRIEF.md
# Memory Error Injection Unit

This unit sits beside a memory controller's transaction path and corrupts check bits on purpose, so that the error detection and reporting path downstream can be exercised. Each transaction carries its decoded DRAM coordinates (channel, DIMM index within the channel, rank, bank, page, column), a write/read flag, two sections of ECC check bits and a parity bit. Transactions pass straight through. When the unit is armed and the coordinates match the configured pattern, it XORs a mask into the chosen ECC sections and/or flips the parity bit in the same cycle.

Software sets the unit up through a small register port: one write strobe, an address and write data, with combinational read data. The pattern has one compare-enable bit per coordinate field. A field whose bit is clear matches any value. A field whose bit is set must equal its stored value exactly, and that value may be zero. The type register selects repeat or one-shot mode, ECC corruption, parity corruption, and whether reads may also trigger. Register map (decimal addresses): 0 enable, 1 type, 2 section, 3 check-bit mask, 4 compare enables, 5 to 10 match values for channel, DIMM, rank, bank, page and column.

The transaction interface is valid/ready with no storage. `out_valid` follows `txn_valid` and `txn_ready` follows `out_ready`, so back-pressure from the consumer reaches the producer in the same cycle. A transaction counts as taken only in a cycle where valid and ready are both high. Arming state changes only on such a cycle.

Top module: `mem_err_inject`

## Requirements
- R1: After reset the unit is disarmed and every compare-enable bit is clear, so all fields are wildcards. Type, section and mask read 0, and every transaction passes through unchanged with `inj_flag` low.
- R2: Compare-enable bit i (0 channel, 1 DIMM, 2 rank, 3 bank, 4 page, 5 column) gates field i on its own. When the bit is set, the field matches only when the coordinate equals the stored value, including a stored value of zero. When the bit is clear, the field matches any value.
- R3: Section code bit 0 selects the lower check byte (`txn_ecc[SEC_W-1:0]`) and bit 1 selects the upper byte. On injection, the mask is XORed into each selected section. Code 0 leaves both sections unchanged, and an unselected section is never altered.
- R4: Type bit 1 enables ECC corruption and type bit 2 inverts the parity bit. An injection happens only if at least one of these two bits is set.
- R5: Writing a nonzero value to address 0 arms the unit and writing zero disarms it. If an enable write and an injection fall in the same cycle, the write decides the next arming state. The unit never injects while disarmed.
- R6: With type bit 0 (repeat) clear, the unit disarms itself after its first injection.
- R7: With repeat set, the unit injects on every matching accepted transaction and stays armed until software writes zero to address 0.
- R8: A matching write transaction triggers injection. A matching read transaction triggers only when type bit 3 is set.
- R9: Every configuration register reads back the value last written, at its own width. Address 0 reads back the current arming state in bit 0.
- R10: `inj_flag` is high, and the `inj_*` coordinate outputs carry the transaction's coordinates, in exactly the cycle in which the corruption appears on `out_ecc`/`out_parity`. Otherwise the coordinate outputs are zero and check bits pass unchanged.
- R11: `out_valid` equals `txn_valid` and `txn_ready` equals `out_ready`. No injection happens and no arming state changes without a handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | DATA_W | Register write data |
| cfg_rdata | output | DATA_W | Register read data for `cfg_addr` |
| txn_valid | input | 1 | Transaction valid |
| txn_ready | output | 1 | Transaction accepted by consumer |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_chan | input | CH_W | Channel |
| txn_dimm | input | DIMM_W | DIMM within channel |
| txn_rank | input | RANK_W | Rank |
| txn_bank | input | BANK_W | Bank |
| txn_page | input | PAGE_W | Page (row) |
| txn_col | input | COL_W | Column |
| txn_ecc | input | 2*SEC_W | Check bits, two sections |
| txn_parity | input | 1 | Parity bit |
| out_valid | output | 1 | Outgoing valid |
| out_ready | input | 1 | Consumer ready |
| out_ecc | output | 2*SEC_W | Possibly corrupted check bits |
| out_parity | output | 1 | Possibly inverted parity |
| inj_flag | output | 1 | Injection applied this cycle |
| inj_chan | output | CH_W | Channel of injected transaction |
| inj_dimm | output | DIMM_W | DIMM of injected transaction |
| inj_rank | output | RANK_W | Rank of injected transaction |
| inj_bank | output | BANK_W | Bank of injected transaction |
| inj_page | output | PAGE_W | Page of injected transaction |
| inj_col | output | COL_W | Column of injected transaction |

## Verification
The assertions assume that the coordinate, check-bit and write inputs are stable and known whenever `txn_valid` is high, and that a register write to address 0 is the only way software changes arming. The bench changes transaction inputs and register writes only at falling edges. It holds `txn_valid` high for exactly one rising edge per transaction, and it drops `out_ready` only in the back-pressure test. Match values are stored at full width, with coordinates zero-extended, so the bench writes only in-range values.

// File: rtl/err_inj_pkg.sv
package err_inj_pkg;

  localparam int NFIELD = 6;

  // register addresses
  typedef enum logic [3:0] {
    REG_CTRL  = 4'd0,
    REG_TYPE  = 4'd1,
    REG_SECT  = 4'd2,
    REG_MASK  = 4'd3,
    REG_CMPEN = 4'd4,
    REG_FLD0  = 4'd5
  } reg_addr_e;

  // field order inside the packed coordinate vector and compare enables
  localparam int F_CHAN = 0;
  localparam int F_DIMM = 1;
  localparam int F_RANK = 2;
  localparam int F_BANK = 3;
  localparam int F_PAGE = 4;
  localparam int F_COL  = 5;

  // type register bits
  localparam int TB_REPEAT = 0;
  localparam int TB_ECC    = 1;
  localparam int TB_PAR    = 2;
  localparam int TB_RDTRIG = 3;
  localparam int TYPE_W    = 4;

endpackage

// File: rtl/inj_cfg_regs.sv
module inj_cfg_regs
  import err_inj_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEC_W  = 8,
  parameter int FW     = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_wr,
  input  logic [3:0]                   cfg_addr,
  input  logic [DATA_W-1:0]            cfg_wdata,
  output logic [DATA_W-1:0]            cfg_rdata,
  input  logic                         fire,
  output logic                         armed,
  output logic [TYPE_W-1:0]            typ,
  output logic [1:0]                   sect,
  output logic [SEC_W-1:0]             mask,
  output logic [NFIELD-1:0]            cmp_en,
  output logic [NFIELD-1:0][FW-1:0]    pat
);

  logic ctrl_wr;
  assign ctrl_wr = cfg_wr && (cfg_addr == REG_CTRL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      typ    <= '0;
      sect   <= '0;
      mask   <= '0;
      cmp_en <= '0;
    end else begin
      if (ctrl_wr)
        armed <= |cfg_wdata;
      else if (fire && !typ[TB_REPEAT])
        armed <= 1'b0;
      if (cfg_wr && cfg_addr == REG_TYPE)  typ    <= cfg_wdata[TYPE_W-1:0];
      if (cfg_wr && cfg_addr == REG_SECT)  sect   <= cfg_wdata[1:0];
      if (cfg_wr && cfg_addr == REG_MASK)  mask   <= cfg_wdata[SEC_W-1:0];
      if (cfg_wr && cfg_addr == REG_CMPEN) cmp_en <= cfg_wdata[NFIELD-1:0];
    end
  end

  for (genvar i = 0; i < NFIELD; i++) begin : g_pat
    always_ff @(posedge clk) begin
      if (!rst_n)
        pat[i] <= '0;
      else if (cfg_wr && cfg_addr == 4'(int'(REG_FLD0) + i))
        pat[i] <= cfg_wdata[FW-1:0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      REG_CTRL:  cfg_rdata = DATA_W'(armed);
      REG_TYPE:  cfg_rdata = DATA_W'(typ);
      REG_SECT:  cfg_rdata = DATA_W'(sect);
      REG_MASK:  cfg_rdata = DATA_W'(mask);
      REG_CMPEN: cfg_rdata = DATA_W'(cmp_en);
      default: begin
        for (int i = 0; i < NFIELD; i++)
          if (cfg_addr == 4'(int'(REG_FLD0) + i)) cfg_rdata = DATA_W'(pat[i]);
      end
    endcase
  end

  AST_ARM_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && (cfg_wdata != '0) |=> armed); // R5
  AST_DISARM_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && (cfg_wdata == '0) |=> !armed); // R5
  AST_ONESHOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !typ[TB_REPEAT] && !ctrl_wr |=> !armed); // R6
  AST_REPEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fire && typ[TB_REPEAT] && !ctrl_wr |=> armed); // R7

endmodule

// File: rtl/inj_addr_match.sv
module inj_addr_match
  import err_inj_pkg::*;
#(
  parameter int FW = 16
) (
  input  logic [NFIELD-1:0]         cmp_en,
  input  logic [NFIELD-1:0][FW-1:0] pat,
  input  logic [NFIELD-1:0][FW-1:0] coord,
  output logic                      hit
);

  logic [NFIELD-1:0] fld_ok;

  for (genvar i = 0; i < NFIELD; i++) begin : g_fld
    assign fld_ok[i] = !cmp_en[i] || (pat[i] == coord[i]);
  end

  assign hit = &fld_ok;

endmodule

// File: rtl/inj_corrupt.sv
module inj_corrupt #(
  parameter int SEC_W = 8
) (
  input  logic               apply,
  input  logic               do_ecc,
  input  logic               do_par,
  input  logic [1:0]         sect,
  input  logic [SEC_W-1:0]   mask,
  input  logic [2*SEC_W-1:0] ecc_in,
  input  logic               par_in,
  output logic [2*SEC_W-1:0] ecc_out,
  output logic               par_out
);

  for (genvar s = 0; s < 2; s++) begin : g_sec
    logic flip_sec;
    assign flip_sec = apply && do_ecc && sect[s];
    assign ecc_out[s*SEC_W +: SEC_W] =
      ecc_in[s*SEC_W +: SEC_W] ^ (flip_sec ? mask : '0);
  end

  assign par_out = par_in ^ (apply && do_par);

  always_comb begin
    AST_LOW_UNTOUCHED: assert (sect[0] || ecc_out[SEC_W-1:0] == ecc_in[SEC_W-1:0]); // R3
    AST_HIGH_UNTOUCHED: assert (sect[1] || ecc_out[2*SEC_W-1:SEC_W] == ecc_in[2*SEC_W-1:SEC_W]); // R3
  end

endmodule

// File: rtl/mem_err_inject.sv
module mem_err_inject
  import err_inj_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CH_W   = 2,
  parameter int DIMM_W = 2,
  parameter int RANK_W = 2,
  parameter int BANK_W = 3,
  parameter int PAGE_W = 16,
  parameter int COL_W  = 12,
  parameter int SEC_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_wr,
  input  logic [3:0]          cfg_addr,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  input  logic                txn_valid,
  output logic                txn_ready,
  input  logic                txn_write,
  input  logic [CH_W-1:0]     txn_chan,
  input  logic [DIMM_W-1:0]   txn_dimm,
  input  logic [RANK_W-1:0]   txn_rank,
  input  logic [BANK_W-1:0]   txn_bank,
  input  logic [PAGE_W-1:0]   txn_page,
  input  logic [COL_W-1:0]    txn_col,
  input  logic [2*SEC_W-1:0]  txn_ecc,
  input  logic                txn_parity,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [2*SEC_W-1:0]  out_ecc,
  output logic                out_parity,
  output logic                inj_flag,
  output logic [CH_W-1:0]     inj_chan,
  output logic [DIMM_W-1:0]   inj_dimm,
  output logic [RANK_W-1:0]   inj_rank,
  output logic [BANK_W-1:0]   inj_bank,
  output logic [PAGE_W-1:0]   inj_page,
  output logic [COL_W-1:0]    inj_col
);

  localparam int MAX_A = (CH_W > DIMM_W) ? CH_W : DIMM_W;
  localparam int MAX_B = (RANK_W > BANK_W) ? RANK_W : BANK_W;
  localparam int MAX_C = (PAGE_W > COL_W) ? PAGE_W : COL_W;
  localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int FW = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;

  logic                      armed;
  logic [TYPE_W-1:0]         typ;
  logic [1:0]                sect;
  logic [SEC_W-1:0]          mask;
  logic [NFIELD-1:0]         cmp_en;
  logic [NFIELD-1:0][FW-1:0] pat;
  logic [NFIELD-1:0][FW-1:0] coord;
  logic                      hit;
  logic                      handshake;
  logic                      trig_ok;
  logic                      fire;

  assign coord[F_CHAN] = FW'(txn_chan);
  assign coord[F_DIMM] = FW'(txn_dimm);
  assign coord[F_RANK] = FW'(txn_rank);
  assign coord[F_BANK] = FW'(txn_bank);
  assign coord[F_PAGE] = FW'(txn_page);
  assign coord[F_COL]  = FW'(txn_col);

  // pass-through stream: no storage at the edge
  assign out_valid = txn_valid;
  assign txn_ready = out_ready;
  assign handshake = txn_valid && out_ready;

  assign trig_ok = txn_write || typ[TB_RDTRIG];
  assign fire = handshake && armed && hit && trig_ok &&
                (typ[TB_ECC] || typ[TB_PAR]);

  inj_cfg_regs #(.DATA_W(DATA_W), .SEC_W(SEC_W), .FW(FW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fire(fire),
    .armed(armed), .typ(typ), .sect(sect), .mask(mask),
    .cmp_en(cmp_en), .pat(pat)
  );

  inj_addr_match #(.FW(FW)) u_match (
    .cmp_en(cmp_en), .pat(pat), .coord(coord), .hit(hit)
  );

  inj_corrupt #(.SEC_W(SEC_W)) u_corrupt (
    .apply(fire), .do_ecc(typ[TB_ECC]), .do_par(typ[TB_PAR]),
    .sect(sect), .mask(mask), .ecc_in(txn_ecc), .par_in(txn_parity),
    .ecc_out(out_ecc), .par_out(out_parity)
  );

  assign inj_flag = fire;
  assign inj_chan = fire ? txn_chan : '0;
  assign inj_dimm = fire ? txn_dimm : '0;
  assign inj_rank = fire ? txn_rank : '0;
  assign inj_bank = fire ? txn_bank : '0;
  assign inj_page = fire ? txn_page : '0;
  assign inj_col  = fire ? txn_col  : '0;

  AST_NO_FIRE_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    inj_flag |-> armed); // R5
  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !inj_flag |-> (out_ecc == txn_ecc) && (out_parity == txn_parity)); // R10
  AST_READ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    inj_flag && !txn_write |-> typ[TB_RDTRIG]); // R8
  AST_FLAG_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
    inj_flag |-> txn_valid && txn_ready); // R11
  AST_ARM_STABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !handshake && !(cfg_wr && cfg_addr == REG_CTRL) |=> $stable(armed)); // R11

endmodule

// File: tb/mem_err_inject_bench.sv
module mem_err_inject_bench;

  typedef struct packed {
    logic [5:0]  cmpen;
    logic [3:0]  typ;
    logic [1:0]  sect;
    logic [7:0]  mask;
    logic        wr;
    logic [1:0]  ch;
    logic [1:0]  dm;
    logic [1:0]  rk;
    logic [2:0]  bk;
    logic [15:0] pg;
    logic [11:0] cl;
    logic [15:0] ecc;
    logic        par;
    logic [15:0] xecc;
    logic        xpar;
    logic        xflag;
  } vec_t;

  // match values: chan 2, dimm 0, rank 1, bank 5, page 0x123, col 0
  localparam int NV = 14;
  localparam vec_t TBL [NV] = '{
    '{6'h00,4'h2,2'd3,8'h40,1'b1,2'd3,2'd1,2'd0,3'd0,16'h0007,12'h009,16'h0000,1'b0,16'h4040,1'b0,1'b1},
    '{6'h01,4'h2,2'd1,8'h40,1'b1,2'd2,2'd3,2'd3,3'd7,16'hFFFF,12'hFFF,16'h00FF,1'b0,16'h00BF,1'b0,1'b1},
    '{6'h01,4'h2,2'd1,8'h40,1'b1,2'd1,2'd0,2'd1,3'd5,16'h0123,12'h000,16'h1234,1'b0,16'h1234,1'b0,1'b0},
    '{6'h02,4'h4,2'd3,8'hFF,1'b1,2'd3,2'd0,2'd3,3'd0,16'h0001,12'h001,16'hAAAA,1'b1,16'hAAAA,1'b0,1'b1},
    '{6'h02,4'h4,2'd3,8'hFF,1'b1,2'd2,2'd1,2'd1,3'd5,16'h0123,12'h000,16'hAAAA,1'b1,16'hAAAA,1'b1,1'b0},
    '{6'h20,4'h6,2'd2,8'h81,1'b1,2'd0,2'd3,2'd0,3'd0,16'h0000,12'h000,16'h0000,1'b0,16'h8100,1'b1,1'b1},
    '{6'h3F,4'h2,2'd1,8'h01,1'b1,2'd2,2'd0,2'd1,3'd5,16'h0123,12'h000,16'h0000,1'b0,16'h0001,1'b0,1'b1},
    '{6'h3F,4'h2,2'd1,8'h01,1'b1,2'd2,2'd0,2'd1,3'd4,16'h0123,12'h000,16'h0000,1'b0,16'h0000,1'b0,1'b0},
    '{6'h1C,4'h2,2'd3,8'h10,1'b1,2'd0,2'd2,2'd1,3'd5,16'h0123,12'h7FF,16'h0000,1'b0,16'h1010,1'b0,1'b1},
    '{6'h1C,4'h2,2'd3,8'h10,1'b1,2'd0,2'd2,2'd1,3'd5,16'h0124,12'h7FF,16'h0000,1'b0,16'h0000,1'b0,1'b0},
    '{6'h00,4'h2,2'd3,8'hFF,1'b0,2'd1,2'd1,2'd1,3'd1,16'h0001,12'h001,16'h0000,1'b0,16'h0000,1'b0,1'b0},
    '{6'h00,4'hA,2'd3,8'h03,1'b0,2'd1,2'd1,2'd1,3'd1,16'h0001,12'h001,16'h0000,1'b0,16'h0303,1'b0,1'b1},
    '{6'h00,4'h2,2'd0,8'hFF,1'b1,2'd1,2'd1,2'd1,3'd1,16'h0001,12'h001,16'h5A5A,1'b0,16'h5A5A,1'b0,1'b1},
    '{6'h00,4'h0,2'd3,8'hFF,1'b1,2'd1,2'd1,2'd1,3'd1,16'h0001,12'h001,16'h5A5A,1'b0,16'h5A5A,1'b0,1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        txn_valid = 1'b0;
  logic        txn_ready;
  logic        txn_write = 1'b0;
  logic [1:0]  txn_chan = '0, txn_dimm = '0, txn_rank = '0;
  logic [2:0]  txn_bank = '0;
  logic [15:0] txn_page = '0;
  logic [11:0] txn_col = '0;
  logic [15:0] txn_ecc = '0;
  logic        txn_parity = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_ecc;
  logic        out_parity;
  logic        inj_flag;
  logic [1:0]  inj_chan, inj_dimm, inj_rank;
  logic [2:0]  inj_bank;
  logic [15:0] inj_page;
  logic [11:0] inj_col;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mem_err_inject u_mem_err_inject (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .txn_valid(txn_valid),
    .txn_ready(txn_ready), .txn_write(txn_write), .txn_chan(txn_chan),
    .txn_dimm(txn_dimm), .txn_rank(txn_rank), .txn_bank(txn_bank),
    .txn_page(txn_page), .txn_col(txn_col), .txn_ecc(txn_ecc),
    .txn_parity(txn_parity), .out_valid(out_valid), .out_ready(out_ready),
    .out_ecc(out_ecc), .out_parity(out_parity), .inj_flag(inj_flag),
    .inj_chan(inj_chan), .inj_dimm(inj_dimm), .inj_rank(inj_rank),
    .inj_bank(inj_bank), .inj_page(inj_page), .inj_col(inj_col)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_addr = a;
    #2 d = cfg_rdata;
  endtask

  // drive one transaction for one rising edge; outputs sampled mid-cycle
  task automatic txn(input logic wr, input logic [1:0] ch, input logic [1:0] dm,
                     input logic [1:0] rk, input logic [2:0] bk, input logic [15:0] pg,
                     input logic [11:0] cl, input logic [15:0] ecc, input logic par,
                     output logic [15:0] oe, output logic op, output logic of);
    @(negedge clk);
    txn_valid = 1'b1; txn_write = wr; txn_chan = ch; txn_dimm = dm;
    txn_rank = rk; txn_bank = bk; txn_page = pg; txn_col = cl;
    txn_ecc = ecc; txn_parity = par;
    #2;
    oe = out_ecc; op = out_parity; of = inj_flag;
    @(negedge clk);
    txn_valid = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [15:0] oe;
    logic        op, of;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rreg(4'd0, rd); chk("R1 ctrl", rd, 0);
    rreg(4'd4, rd); chk("R1 cmpen", rd, 0);
    rreg(4'd1, rd); chk("R1 type", rd, 0);
    rreg(4'd2, rd); chk("R1 sect", rd, 0);
    rreg(4'd3, rd); chk("R1 mask", rd, 0);
    txn(1'b1, 2'd2, 2'd0, 2'd1, 3'd5, 16'h0123, 12'h0, 16'h1357, 1'b1, oe, op, of);
    chk("R1 ecc", 32'(oe), 32'h1357);
    chk("R1 par", 32'(op), 1);
    chk("R1 flag", 32'(of), 0);

    // R9: readback of match values and config
    wreg(4'd5, 32'd2); wreg(4'd6, 32'd0); wreg(4'd7, 32'd1);
    wreg(4'd8, 32'd5); wreg(4'd9, 32'h123); wreg(4'd10, 32'd0);
    wreg(4'd1, 32'hF); wreg(4'd2, 32'd3); wreg(4'd3, 32'hA5); wreg(4'd4, 32'h2A);
    rreg(4'd5, rd); chk("R9 chan", rd, 2);
    rreg(4'd7, rd); chk("R9 rank", rd, 1);
    rreg(4'd8, rd); chk("R9 bank", rd, 5);
    rreg(4'd9, rd); chk("R9 page", rd, 32'h123);
    rreg(4'd1, rd); chk("R9 type", rd, 32'hF);
    rreg(4'd2, rd); chk("R9 sect", rd, 3);
    rreg(4'd3, rd); chk("R9 mask", rd, 32'hA5);
    rreg(4'd4, rd); chk("R9 cmpen", rd, 32'h2A);

    // table walk: R2 R3 R4 R6 R8
    for (int i = 0; i < NV; i++) begin
      wreg(4'd1, 32'(TBL[i].typ));
      wreg(4'd2, 32'(TBL[i].sect));
      wreg(4'd3, 32'(TBL[i].mask));
      wreg(4'd4, 32'(TBL[i].cmpen));
      wreg(4'd0, 32'd1);
      txn(TBL[i].wr, TBL[i].ch, TBL[i].dm, TBL[i].rk, TBL[i].bk, TBL[i].pg,
          TBL[i].cl, TBL[i].ecc, TBL[i].par, oe, op, of);
      chk($sformatf("R2/R3/R8 vec%0d ecc", i), 32'(oe), 32'(TBL[i].xecc));
      chk($sformatf("R4 vec%0d par", i), 32'(op), 32'(TBL[i].xpar));
      chk($sformatf("R2/R8 vec%0d flag", i), 32'(of), 32'(TBL[i].xflag));
      rreg(4'd0, rd);
      chk($sformatf("R6 vec%0d armed", i), rd, TBL[i].xflag ? 0 : 1);
      wreg(4'd0, 32'd0);
    end

    // R7: repeat mode with coordinates (R10)
    wreg(4'd4, 32'h0); wreg(4'd1, 32'h3); wreg(4'd2, 32'd1); wreg(4'd3, 32'h01);
    wreg(4'd0, 32'd7);
    @(negedge clk);
    txn_valid = 1'b1; txn_write = 1'b1; txn_chan = 2'd3; txn_dimm = 2'd2;
    txn_rank = 2'd1; txn_bank = 3'd6; txn_page = 16'hBEEF; txn_col = 12'h5A5;
    txn_ecc = 16'h0; txn_parity = 1'b0;
    #2;
    chk("R10 flag", 32'(inj_flag), 1);
    chk("R10 ecc", 32'(out_ecc), 1);
    chk("R10 chan", 32'(inj_chan), 3);
    chk("R10 dimm", 32'(inj_dimm), 2);
    chk("R10 bank", 32'(inj_bank), 6);
    chk("R10 page", 32'(inj_page), 32'hBEEF);
    chk("R10 col", 32'(inj_col), 32'h5A5);
    @(negedge clk);
    txn_valid = 1'b0;
    #2;
    chk("R10 idle coords", 32'(inj_page), 0);
    txn(1'b1, 2'd0, 2'd0, 2'd0, 3'd0, 16'h0, 12'h0, 16'h0, 1'b0, oe, op, of);
    chk("R7 second flag", 32'(of), 1);
    chk("R7 second ecc", 32'(oe), 1);
    rreg(4'd0, rd); chk("R7 still armed", rd, 1);
    wreg(4'd0, 32'd0);
    rreg(4'd0, rd); chk("R5 disarm", rd, 0);
    txn(1'b1, 2'd0, 2'd0, 2'd0, 3'd0, 16'h0, 12'h0, 16'h0, 1'b0, oe, op, of);
    chk("R5 no inject disarmed", 32'(of), 0);

    // R6: one-shot, second txn untouched
    wreg(4'd1, 32'h2); wreg(4'd0, 32'd1);
    txn(1'b1, 2'd0, 2'd0, 2'd0, 3'd0, 16'h0, 12'h0, 16'h0, 1'b0, oe, op, of);
    chk("R6 first flag", 32'(of), 1);
    txn(1'b1, 2'd0, 2'd0, 2'd0, 3'd0, 16'h0, 12'h0, 16'h0, 1'b0, oe, op, of);
    chk("R6 second flag", 32'(of), 0);
    chk("R6 second ecc", 32'(oe), 0);

    // R11: back-pressure
    wreg(4'd0, 32'd1);
    @(negedge clk);
    out_ready = 1'b0; txn_valid = 1'b1; txn_write = 1'b1; txn_ecc = 16'h0;
    #2;
    chk("R11 out_valid", 32'(out_valid), 1);
    chk("R11 txn_ready", 32'(txn_ready), 0);
    chk("R11 no flag stalled", 32'(inj_flag), 0);
    chk("R11 ecc stalled", 32'(out_ecc), 0);
    @(negedge clk);
    txn_valid = 1'b0; out_ready = 1'b1;
    rreg(4'd0, rd); chk("R11 armed kept", rd, 1);
    txn(1'b1, 2'd0, 2'd0, 2'd0, 3'd0, 16'h0, 12'h0, 16'h0, 1'b0, oe, op, of);
    chk("R11 flag after ready", 32'(of), 1);

    // R5: enable write in same cycle as one-shot injection wins
    wreg(4'd0, 32'd1);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 4'd0; cfg_wdata = 32'd1;
    txn_valid = 1'b1; txn_write = 1'b1;
    #2 chk("R5 flag same cycle", 32'(inj_flag), 1);
    @(negedge clk);
    cfg_wr = 1'b0; txn_valid = 1'b0;
    rreg(4'd0, rd); chk("R5 write wins", rd, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule